// File: doc/BRIEF.md
# Serial Control Port with Clock-Output Mode

This block is the control port that a host microcontroller uses to load a bank of sixteen control registers over three wires: a serial clock, a shared data line and a framing enable. All three wires are sampled and synchronized into the block's own system clock. While enable is high, each rising serial-clock edge shifts one bit into a frame register. When enable falls, a frame of exactly the full length is decoded into a data word and a 4-bit address, and the addressed register is loaded.

One address is a command and not a register. If it arrives while a permit bit in the power-control register is set, the shared data line is turned around: the block drives it and sends out a recovered clock that it receives from elsewhere. In that state the port ignores all serial traffic. The next falling edge of enable hands the line back to the host, and normal writes work again right away. The power-control register also drives a set of section-disable outputs and a derived enable for a shared reference counter.

Top module: `sctl_port`

## Requirements
- R1: After reset, ser_doe and ser_dout are 0, every register reads 0, section_off is all zeros and ref_cnt_en is 1.
- R2: A frame is 28 bits shifted MSB first on rising ser_clk edges while ser_en is high. The first 24 bits are the data word and the last 4 bits are the address. On the falling edge of ser_en, register[address] takes the data word, which appears on regs_flat[address*24 +: 24].
- R3: A frame that holds fewer than 28 bits when ser_en falls is dropped, and no register changes.
- R4: A full frame to address 11, while bit 20 of register 5 is 1, sets ser_doe to 1 after ser_en falls. Register 11 is not written.
- R5: A full frame to address 11, while bit 20 of register 5 is 0, leaves ser_doe at 0 and changes no register.
- R6: While ser_doe is 1, ser_dout follows rclk_in with one system-clock delay. While ser_doe is 0, ser_dout is 0.
- R7: While the clock-output mode is active, serial clocks and data change no register and do not turn the line back. A frame sent in that mode writes nothing.
- R8: In clock-output mode, the next falling edge of ser_en sets ser_doe back to 0, and the next full frame writes its register normally.
- R9: section_off[10:0] follows register 5 bits 10..0, and section_off[11] follows register 5 bit 18 (1 = section disabled).
- R10: ref_cnt_en is 0 exactly when register 5 bits 1, 2 and 3 are all 1, and is 1 otherwise.
- R11: A frame longer than 28 bits uses its last 28 bits shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Host serial clock |
| ser_en | input | 1 | Host frame enable |
| ser_din | input | 1 | Data line as seen at the pin (input side) |
| rclk_in | input | 1 | Recovered clock to send out in clock-output mode |
| ser_dout | output | 1 | Value driven onto the data line |
| ser_doe | output | 1 | Drive enable for the data line (1 = block drives) |
| regs_flat | output | 384 | All sixteen 24-bit registers, register n at bits n*24 +: 24 |
| section_off | output | 12 | Section-disable controls from register 5 |
| ref_cnt_en | output | 1 | Reference-counter enable, 0 when all three PLL disables are set |

## Verification
If the mode state machine is wrong, the fault shows within a few system clocks of an enable falling edge as a wrong ser_doe level. It also shows as a ser_dout that fails to track rclk_in. If the bit counter or the shift register is corrupted, the wrong register changes or a truncated or padded frame gets through, and regs_flat shows this about five cycles after the frame closes. The decoders of register 5 are checked about one cycle after that register settles, through section_off and ref_cnt_en.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_CLKOUT = 1'b1
  } sctl_mode_e;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_lvl
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[STAGES-2:0], d_in[g]};
    end
    assign d_lvl[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              bit_in,
  input  logic              sclk_rise,
  input  logic              sen_lvl,
  input  logic              sen_rise,
  input  logic              sen_fall,
  output logic              frm_vld,
  output logic [ADDR_W-1:0] frm_addr,
  output logic [DATA_W-1:0] frm_data
);
  localparam int FRAME = DATA_W + ADDR_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME);

  logic [FRAME-1:0] sr;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      cnt      <= '0;
      frm_vld  <= 1'b0;
      frm_addr <= '0;
      frm_data <= '0;
    end else begin
      frm_vld <= 1'b0;
      if (sen_rise) begin
        cnt <= '0;
      end else if (sclk_rise && sen_lvl && !hold) begin
        sr <= {sr[FRAME-2:0], bit_in};
        if (cnt != FULL) cnt <= cnt + 1'b1;
      end
      if (sen_fall) begin
        cnt <= '0;
        if (cnt == FULL && !hold) begin
          frm_vld  <= 1'b1;
          frm_addr <= sr[ADDR_W-1:0];
          frm_data <= sr[FRAME-1:ADDR_W];
        end
      end
    end
  end

  // R3: a short frame never yields a valid strobe
  a_r3_short_dropped: assert property (@(posedge clk) disable iff (rst)
    (sen_fall && cnt != FULL) |=> !frm_vld);
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs #(
  parameter int DATA_W   = 24,
  parameter int ADDR_W   = 4,
  parameter int CMD_ADDR = 11
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [(2**ADDR_W)*DATA_W-1:0]    regs_flat
);
  localparam int NREGS = 2**ADDR_W;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [DATA_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) r <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g)) r <= wr_data;
    end
    assign regs_flat[g*DATA_W +: DATA_W] = r;
  end

  // R4: the command address is never stored
  a_r4_cmd_not_stored: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == ADDR_W'(CMD_ADDR)));
endmodule

// File: rtl/sctl_mode.sv
module sctl_mode
  import sctl_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CMD_ADDR = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_vld,
  input  logic [ADDR_W-1:0] frm_addr,
  input  logic              allow,
  input  logic              sen_fall,
  input  logic              rclk_in,
  output logic              mode_on,
  output logic              pin_oe,
  output logic              pin_out
);
  sctl_mode_e st, st_nxt;
  logic       is_cmd;

  assign is_cmd = frm_vld && (frm_addr == ADDR_W'(CMD_ADDR));

  always_comb begin
    st_nxt = st;
    case (st)
      MODE_NORMAL: if (is_cmd && allow) st_nxt = MODE_CLKOUT;
      MODE_CLKOUT: if (sen_fall)        st_nxt = MODE_NORMAL;
      default:                          st_nxt = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= MODE_NORMAL;
      pin_oe  <= 1'b0;
      pin_out <= 1'b0;
    end else begin
      st      <= st_nxt;
      pin_oe  <= (st_nxt == MODE_CLKOUT);
      pin_out <= (st_nxt == MODE_CLKOUT) && rclk_in;
    end
  end

  assign mode_on = (st == MODE_CLKOUT);

  a_r4_enter: assert property (@(posedge clk) disable iff (rst)
    (!mode_on && is_cmd && allow) |=> pin_oe);
  a_r5_no_enter: assert property (@(posedge clk) disable iff (rst)
    (!mode_on && !pin_oe && is_cmd && !allow) |=> !pin_oe);
  a_r8_exit: assert property (@(posedge clk) disable iff (rst)
    (mode_on && sen_fall) |=> !pin_oe);
  a_r6_quiet_when_input: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_out);
endmodule

// File: rtl/sctl_pdec.sv
module sctl_pdec #(
  parameter int PD_W  = 12,
  parameter int PLL_N = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PD_W-1:0]  pd_bits,
  input  logic [PLL_N-1:0] pll_off,
  output logic [PD_W-1:0]  section_off,
  output logic             ref_cnt_en
);
  for (genvar g = 0; g < PD_W; g++) begin : g_pd
    always_ff @(posedge clk) begin
      if (rst) section_off[g] <= 1'b0;
      else     section_off[g] <= pd_bits[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ref_cnt_en <= 1'b1;
    else     ref_cnt_en <= ~(&pll_off);
  end

  // R10: all PLLs disabled turns the reference counter off
  a_r10_ref_off: assert property (@(posedge clk) disable iff (rst)
    (&pll_off) |=> !ref_cnt_en);
  // R9: disable bits reach the outputs one cycle later
  a_r9_pd_follow: assert property (@(posedge clk) disable iff (rst)
    pd_bits[PD_W-1] |=> section_off[PD_W-1]);
endmodule

// File: rtl/sctl_port.sv
module sctl_port #(
  parameter int DATA_W      = 24,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CMD_ADDR    = 11,
  parameter int PD_REG      = 5,
  parameter int MODE_BIT    = 20,
  parameter int PD_LO_W     = 11,
  parameter int PD_XTRA_BIT = 18,
  parameter int PLL_LSB     = 1,
  parameter int PLL_N       = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ser_clk,
  input  logic                          ser_en,
  input  logic                          ser_din,
  input  logic                          rclk_in,
  output logic                          ser_dout,
  output logic                          ser_doe,
  output logic [(2**ADDR_W)*DATA_W-1:0] regs_flat,
  output logic [PD_LO_W:0]              section_off,
  output logic                          ref_cnt_en
);
  logic [2:0]        lvl;
  logic              sclk_prev, sen_prev;
  logic              sclk_rise, sen_rise, sen_fall;
  logic              frm_vld, mode_on, wr_en;
  logic [ADDR_W-1:0] frm_addr;
  logic [DATA_W-1:0] frm_data;
  logic [DATA_W-1:0] pd_reg;

  sctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in({ser_din, ser_en, ser_clk}), .d_lvl(lvl));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      sen_prev  <= 1'b0;
    end else begin
      sclk_prev <= lvl[0];
      sen_prev  <= lvl[1];
    end
  end

  assign sclk_rise = lvl[0] & ~sclk_prev;
  assign sen_rise  = lvl[1] & ~sen_prev;
  assign sen_fall  = ~lvl[1] & sen_prev;

  sctl_shift #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shift (
    .clk(clk), .rst(rst), .hold(mode_on), .bit_in(lvl[2]),
    .sclk_rise(sclk_rise), .sen_lvl(lvl[1]), .sen_rise(sen_rise),
    .sen_fall(sen_fall), .frm_vld(frm_vld), .frm_addr(frm_addr),
    .frm_data(frm_data));

  assign wr_en = frm_vld && !mode_on && (frm_addr != ADDR_W'(CMD_ADDR));

  sctl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(frm_addr),
    .wr_data(frm_data), .regs_flat(regs_flat));

  assign pd_reg = regs_flat[PD_REG*DATA_W +: DATA_W];

  sctl_mode #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_mode (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_addr(frm_addr),
    .allow(pd_reg[MODE_BIT]), .sen_fall(sen_fall), .rclk_in(rclk_in),
    .mode_on(mode_on), .pin_oe(ser_doe), .pin_out(ser_dout));

  sctl_pdec #(.PD_W(PD_LO_W + 1), .PLL_N(PLL_N)) u_pdec (
    .clk(clk), .rst(rst),
    .pd_bits({pd_reg[PD_XTRA_BIT], pd_reg[PD_LO_W-1:0]}),
    .pll_off(pd_reg[PLL_LSB +: PLL_N]),
    .section_off(section_off), .ref_cnt_en(ref_cnt_en));

  // R7: nothing is written while the line carries the recovered clock
  a_r7_no_write_in_mode: assert property (@(posedge clk) disable iff (rst)
    mode_on |-> !wr_en);
endmodule

// File: tb/sctl_port_bench.sv
module sctl_port_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_en = 1'b0, ser_din = 1'b0, rclk_in = 1'b0;
  logic ser_dout, ser_doe, ref_cnt_en;
  logic [383:0] regs_flat;
  logic [11:0]  section_off;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sctl_port u_sctl_port (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_en(ser_en),
    .ser_din(ser_din), .rclk_in(rclk_in), .ser_dout(ser_dout),
    .ser_doe(ser_doe), .regs_flat(regs_flat), .section_off(section_off),
    .ref_cnt_en(ref_cnt_en));

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] rd(input int a);
    return regs_flat[a*24 +: 24];
  endfunction

  task automatic send_bits(input logic [63:0] w, input int n);
    ser_en = 1'b1;
    wait_clk(6);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = w[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
    ser_en = 1'b0;
    wait_clk(12);
  endtask

  task automatic wr(input logic [3:0] a, input logic [23:0] d);
    send_bits({36'd0, d, a}, 28);
  endtask

  task automatic en_pulse();
    ser_en = 1'b1;
    wait_clk(8);
    ser_en = 1'b0;
    wait_clk(12);
  endtask

  task automatic t_reset();
    chk("R1 doe", ser_doe, 0);
    chk("R1 dout", ser_dout, 0);
    chk("R1 regs", 32'(regs_flat != '0), 0);
    chk("R1 section_off", section_off, 0);
    chk("R1 ref_en", ref_cnt_en, 1);
  endtask

  task automatic t_write();
    wr(4'd3, 24'hA5C3F1);
    wr(4'd0, 24'h123456);
    wr(4'd15, 24'hFFFFFF);
    chk("R2 reg3", rd(3), 24'hA5C3F1);
    chk("R2 reg0", rd(0), 24'h123456);
    chk("R2 reg15", rd(15), 24'hFFFFFF);
    chk("R2 reg1 untouched", rd(1), 0);
  endtask

  task automatic t_short();
    send_bits({36'd0, 24'h00BEEF, 4'd3} >> 1, 27);
    chk("R3 short frame", rd(3), 24'hA5C3F1);
    send_bits({40'd0, 24'h0000AA} >> 0, 24);
    chk("R3 short frame reg10", rd(10), 0);
  endtask

  task automatic t_long();
    send_bits({32'd0, 4'hD, 24'h0F0F0F, 4'd7}, 32);
    chk("R11 long frame", rd(7), 24'h0F0F0F);
  endtask

  task automatic t_pd();
    wr(4'd5, 24'h0402AA);
    wait_clk(3);
    chk("R9 section_off", section_off, 12'hAAA);
    chk("R10 ref_en partial", ref_cnt_en, 1);
    wr(4'd5, 24'h00000E);
    wait_clk(3);
    chk("R10 ref_en all off", ref_cnt_en, 0);
    chk("R9 section_off low", section_off, 12'h00E);
    wr(4'd5, 24'h00000C);
    wait_clk(3);
    chk("R10 ref_en two off", ref_cnt_en, 1);
  endtask

  task automatic t_noentry();
    wr(4'd5, 24'h000000);
    wr(4'd11, 24'h123123);
    chk("R5 doe stays low", ser_doe, 0);
    chk("R5 reg11 unchanged", rd(11), 0);
  endtask

  task automatic t_entry_clock();
    wr(4'd5, 24'h100000);
    wr(4'd11, 24'h000001);
    chk("R4 doe high", ser_doe, 1);
    chk("R4 reg11 unchanged", rd(11), 0);
    chk("R4 reg5 kept", rd(5), 24'h100000);
    rclk_in = 1'b1;
    wait_clk(1);
    chk("R6 dout high", ser_dout, 1);
    rclk_in = 1'b0;
    wait_clk(1);
    chk("R6 dout low", ser_dout, 0);
    rclk_in = 1'b1;
    wait_clk(1);
    chk("R6 dout high again", ser_dout, 1);
    rclk_in = 1'b0;
    // R7: clocks with enable low must not leave the mode
    for (int i = 0; i < 6; i++) begin
      ser_din = i[0];
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(4);
    end
    chk("R7 still driving", ser_doe, 1);
  endtask

  task automatic t_ignore();
    wr(4'd2, 24'h111111);
    chk("R7 frame in mode ignored", rd(2), 0);
    chk("R7 frame edge releases line", ser_doe, 0);
  endtask

  task automatic t_exit();
    wr(4'd11, 24'h0);
    chk("R8 re-entered", ser_doe, 1);
    en_pulse();
    chk("R8 doe low after pulse", ser_doe, 0);
    wr(4'd5, 24'h000000);
    chk("R8 write after exit", rd(5), 0);
    rclk_in = 1'b1;
    wait_clk(3);
    chk("R6 dout idle when input", ser_dout, 0);
    rclk_in = 1'b0;
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_write();
    t_short();
    t_long();
    t_pd();
    t_noentry();
    t_entry_clock();
    t_ignore();
    t_exit();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule